// File: doc/BRIEF.md
# Ring-Rotating Block Matrix Multiplier

This block multiplies two square N-by-N unsigned integer matrices, C = A x B, on a ring of P processing elements. Every element owns a local memory, one multiply-accumulate unit and its share of a fixed sequencer. Element i holds the i-th group of N/P rows of A for the whole run. It starts with the i-th group of N/P columns of B. It computes the part of C that this pair of blocks covers. Then it hands its B block to element (i+1) mod P. After P rounds every element has seen every column block, so its rows of C are complete.

The next B block travels into a shadow buffer while the current one is being multiplied. The ring therefore adds no cycles, and a full product takes N^3/P clock cycles. A host writes A and B one element at a time through a load port, pulses start, waits for done and reads C back one element at a time through a read port. The read port answers one cycle after it is addressed. A and B are kept after a run, so a second start recomputes the product, and either matrix can be replaced on its own before the next start.

Top module: `rrmm_top`

## Requirements
- R1: After reset, done is 0 and every C element reads as 0.
- R2: When done is 1, C[r][c] equals the exact sum over k of A[r][k]*B[k][c] with no wrap. This holds even when every input is 2^DW-1, because the accumulator is 2*DW+ceil(log2 N) bits wide.
- R3: done goes from 0 to 1 exactly N^3/P rising clock edges after the edge that samples start high. done is 0 during all the edges before that.
- R4: Each round, the B block that a ring neighbour forwards fills all N*N/P entries of the receiving element's shadow buffer before the buffers swap. No cycles are spent on communication beyond the N^3/P compute cycles.
- R5: Once set, done stays 1 until start is next sampled high. A start pulse while the product is running has no effect on the completion time.
- R6: A load is written when ld_we=1 at a clock edge and the block is not running. ld_sel=0 selects A[ld_row][ld_col] and ld_sel=1 selects B[ld_row][ld_col]. Loads during a run are ignored.
- R7: rd_data shows C[rd_row][rd_col] one clock edge after the address is applied, with rows and columns numbered from 0.
- R8: A and B are kept after a run. Restarting without a reload gives the same C. Reloading only B and restarting gives A x B_new.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_we | input | 1 | Write one matrix element |
| ld_sel | input | 1 | 0 selects A, 1 selects B |
| ld_row | input | clog2(N) | Row of the element to write |
| ld_col | input | clog2(N) | Column of the element to write |
| ld_data | input | DW | Element value, unsigned |
| start | input | 1 | Begins a product when sampled high while idle or done |
| done | output | 1 | The whole C matrix is valid |
| rd_row | input | clog2(N) | Row of the C element to read |
| rd_col | input | clog2(N) | Column of the C element to read |
| rd_data | output | 2*DW+clog2(N) | C element, registered |

## Verification
Completion is due exactly N^3/P edges after the start edge. The bench drives start on a falling edge, counts the falling edges that follow and compares that count with N^3/P, so it can catch a round that runs one cycle short or one cycle long. C is due one edge after a read address is applied. The bench sets the address on a falling edge and samples at the next falling edge, and it also checks that the value just before that edge still belongs to the previous address. Loads and start pulses issued in the middle of a run are followed by a completion-time check and a full compare of C, which shows that they were ignored.

// File: rtl/rrmm_pkg.sv
// Package: shared types and width helpers for the ring block multiplier.
// Assumes nothing beyond IEEE 1800-2017 constant functions.
package rrmm_pkg;

    // Sequencer state of the hardwired ring controller.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } rrmm_state_e;

    // Bits needed to index v items, never less than one.
    function automatic int wbits(input int v);
        return (v > 1) ? $clog2(v) : 1;
    endfunction

endpackage

// File: rtl/rrmm_ctrl.sv
// Module: rrmm_ctrl
// Fixed sequencer shared by all ring elements. It walks P rounds. In each
// round it visits R x R outputs of an element's block, and each output takes
// N MAC steps. During the first N*R steps of a round it also addresses the
// B word that every element forwards to its neighbour.
// Assumes P divides N, with R = N/P rows or columns per block.
module rrmm_ctrl
    import rrmm_pkg::*;
#(
    parameter int N = 4,
    parameter int P = 2
)(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    output logic                         running,
    output logic                         done,
    output logic [wbits(N)-1:0]          kk,
    output logic [wbits(N/P)-1:0]        lc,
    output logic [wbits(N/P)-1:0]        lr,
    output logic [wbits(P)-1:0]          rnd,
    output logic                         swap,
    output logic                         xfer_en,
    output logic [wbits(N*(N/P))-1:0]    xfer_idx
);
    localparam int R   = N / P;
    localparam int KW  = wbits(N);
    localparam int RW  = wbits(R);
    localparam int PW  = wbits(P);
    localparam int BIW = wbits(N * R);

    rrmm_state_e state;
    logic        last_step;
    logic        last_round;
    int          step_in_round;

    // Decode the end of a round, the end of the run and the transfer window.
    always_comb begin
        running       = (state == ST_RUN);
        done          = (state == ST_DONE);
        last_step     = running && (int'(kk) == N - 1) && (int'(lc) == R - 1)
                        && (int'(lr) == R - 1);
        last_round    = (int'(rnd) == P - 1);
        swap          = last_step;
        step_in_round = (int'(lr) * R + int'(lc)) * N + int'(kk);
        xfer_en       = running && (step_in_round < N * R);
        xfer_idx      = BIW'(step_in_round);
    end

    // Advance the nested step counters and the state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            kk    <= '0;
            lc    <= '0;
            lr    <= '0;
            rnd   <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        state <= ST_RUN;
                        kk    <= '0;
                        lc    <= '0;
                        lr    <= '0;
                        rnd   <= '0;
                    end
                end
                ST_RUN: begin
                    if (int'(kk) != N - 1) begin
                        kk <= kk + KW'(1);
                    end else begin
                        kk <= '0;
                        if (int'(lc) != R - 1) begin
                            lc <= lc + RW'(1);
                        end else begin
                            lc <= '0;
                            if (int'(lr) != R - 1) begin
                                lr <= lr + RW'(1);
                            end else begin
                                lr <= '0;
                                if (last_round) begin
                                    rnd   <= '0;
                                    state <= ST_DONE;
                                end else begin
                                    rnd <= rnd + PW'(1);
                                end
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // done rises only after the final step of the final round.
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(last_step && last_round)); // R3

    // done holds until a new start is sampled.
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R5

    // A start pulse during a run does not restart the counters.
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (running && start && !last_step) |=> running); // R5

endmodule

// File: rtl/rrmm_mac.sv
// Module: rrmm_mac
// Unsigned multiply-accumulate unit. sum is the running total including the
// current product. When first is set, the total restarts from zero.
// Assumes AW >= 2*DW + clog2(N), so a full dot product cannot wrap.
module rrmm_mac #(
    parameter int DW = 8,
    parameter int AW = 19
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          first,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [AW-1:0] sum
);
    logic [AW-1:0]   acc;
    logic [2*DW-1:0] prod;
    logic [AW:0]     wide;

    // Form the product and the total, keeping one guard bit.
    always_comb begin
        prod = a * b;
        wide = {1'b0, (first ? {AW{1'b0}} : acc)} + (AW + 1)'(prod);
        sum  = wide[AW-1:0];
    end

    // Hold the running total between steps.
    always_ff @(posedge clk) begin
        if (!rst_n) acc <= '0;
        else if (en) acc <= sum;
    end

    // The guard bit must never be set: the accumulator covers the full sum.
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> !wide[AW]); // R2

endmodule

// File: rtl/rrmm_pe.sv
// Module: rrmm_pe
// One ring element. It keeps R rows of A, two B column-block buffers (the
// active one and a shadow) and R rows of C. It multiplies the active block
// into the C columns of the block it currently holds. It forwards the active
// block to the next element and takes the previous element's block into its
// shadow buffer, then swaps the buffers at the end of each round.
// Assumes loads arrive only while the controller is not running.
module rrmm_pe
    import rrmm_pkg::*;
#(
    parameter int N   = 4,
    parameter int P   = 2,
    parameter int DW  = 8,
    parameter int AW  = 19,
    parameter int IDX = 0
)(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ld_a_we,
    input  logic                        ld_b_we,
    input  logic [wbits(N)-1:0]         ld_row,
    input  logic [wbits(N)-1:0]         ld_col,
    input  logic [DW-1:0]               ld_data,
    input  logic                        running,
    input  logic [wbits(N)-1:0]         kk,
    input  logic [wbits(N/P)-1:0]       lc,
    input  logic [wbits(N/P)-1:0]       lr,
    input  logic [wbits(P)-1:0]         rnd,
    input  logic                        swap,
    input  logic                        xfer_en,
    input  logic [wbits(N*(N/P))-1:0]   xfer_idx,
    input  logic [DW-1:0]               nb_in,
    output logic [DW-1:0]               nb_out,
    input  logic [wbits(N)-1:0]         rd_row,
    input  logic [wbits(N)-1:0]         rd_col,
    output logic [AW-1:0]               rd_val
);
    localparam int R   = N / P;
    localparam int ABW = wbits(R * N);
    localparam int BIW = wbits(N * R);
    localparam int CNW = wbits(N * R + 1);

    logic [DW-1:0]  a_mem [R*N];
    logic [DW-1:0]  b_buf [2][N*R];
    logic [AW-1:0]  c_mem [R*N];
    logic           act;
    logic [CNW-1:0] rx_cnt;

    logic [ABW-1:0] a_ld_idx, a_rd_idx, c_wr_idx, c_rd_idx;
    logic [BIW-1:0] b_ld_idx, b_rd_idx;
    logic [DW-1:0]  a_op, b_op;
    logic [AW-1:0]  mac_sum;
    logic           mac_first, mac_last;
    int             blk;

    // Map global and step coordinates onto local memory addresses.
    always_comb begin
        blk       = (IDX - int'(rnd) + P) % P;
        a_ld_idx  = ABW'((int'(ld_row) % R) * N + int'(ld_col));
        b_ld_idx  = BIW'(int'(ld_row) * R + (int'(ld_col) % R));
        a_rd_idx  = ABW'(int'(lr) * N + int'(kk));
        b_rd_idx  = BIW'(int'(kk) * R + int'(lc));
        c_wr_idx  = ABW'(int'(lr) * N + blk * R + int'(lc));
        c_rd_idx  = ABW'((int'(rd_row) % R) * N + int'(rd_col));
        a_op      = a_mem[a_rd_idx];
        b_op      = b_buf[act][b_rd_idx];
        mac_first = (int'(kk) == 0);
        mac_last  = running && (int'(kk) == N - 1);
        nb_out    = b_buf[act][xfer_idx];
        rd_val    = c_mem[c_rd_idx];
    end

    rrmm_mac #(.DW(DW), .AW(AW)) u_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (running),
        .first (mac_first),
        .a     (a_op),
        .b     (b_op),
        .sum   (mac_sum)
    );

    // Store the resident A rows written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < R * N; i++) a_mem[i] <= '0;
        end else if (ld_a_we) begin
            a_mem[a_ld_idx] <= ld_data;
        end
    end

    // Host loads go to the active buffer, ring words go to the shadow buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < 2; s++)
                for (int i = 0; i < N * R; i++) b_buf[s][i] <= '0;
            act <= 1'b0;
        end else begin
            if (ld_b_we) b_buf[act][b_ld_idx] <= ld_data;
            if (xfer_en) b_buf[~act][xfer_idx] <= nb_in;
            if (swap)    act <= ~act;
        end
    end

    // Count shadow writes in the current round, for the fill check.
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_cnt <= '0;
        else if (swap)    rx_cnt <= '0;
        else if (xfer_en) rx_cnt <= rx_cnt + CNW'(1);
    end

    // Write each finished dot product into its slot of this element's C rows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < R * N; i++) c_mem[i] <= '0;
        end else if (mac_last) begin
            c_mem[c_wr_idx] <= mac_sum;
        end
    end

    // The shadow block is complete by the time the buffers swap.
    AST_SHADOW_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        swap |-> ((int'(rx_cnt) + (xfer_en ? 1 : 0)) == N * R)); // R4

    // No host load reaches the buffers during a run.
    AST_NO_LOAD_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> !(ld_a_we || ld_b_we)); // R6

endmodule

// File: rtl/rrmm_top.sv
// Module: rrmm_top
// Ring of P elements sharing one hardwired controller. It routes host loads
// to the element that owns each A row or B column and closes the ring
// i -> (i+1) mod P for the B blocks. C reads are registered.
// Assumes P divides N and AW covers 2*DW + clog2(N) bits.
module rrmm_top
    import rrmm_pkg::*;
#(
    parameter int N  = 4,
    parameter int P  = 2,
    parameter int DW = 8,
    parameter int AW = 2 * DW + wbits(N)
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_we,
    input  logic                 ld_sel,
    input  logic [wbits(N)-1:0]  ld_row,
    input  logic [wbits(N)-1:0]  ld_col,
    input  logic [DW-1:0]        ld_data,
    input  logic                 start,
    output logic                 done,
    input  logic [wbits(N)-1:0]  rd_row,
    input  logic [wbits(N)-1:0]  rd_col,
    output logic [AW-1:0]        rd_data
);
    localparam int R   = N / P;
    localparam int KW  = wbits(N);
    localparam int RW  = wbits(R);
    localparam int PW  = wbits(P);
    localparam int BIW = wbits(N * R);

    logic           running, swap, xfer_en;
    logic [KW-1:0]  kk;
    logic [RW-1:0]  lc, lr;
    logic [PW-1:0]  rnd;
    logic [BIW-1:0] xfer_idx;
    logic [DW-1:0]  ring [P];
    logic [AW-1:0]  pe_rd [P];
    logic [P-1:0]   a_we, b_we;

    rrmm_ctrl #(.N(N), .P(P)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .running  (running),
        .done     (done),
        .kk       (kk),
        .lc       (lc),
        .lr       (lr),
        .rnd      (rnd),
        .swap     (swap),
        .xfer_en  (xfer_en),
        .xfer_idx (xfer_idx)
    );

    // Pick the element that owns the addressed A row or B column.
    always_comb begin
        for (int i = 0; i < P; i++) begin
            a_we[i] = ld_we && !running && !ld_sel && (int'(ld_row) / R == i);
            b_we[i] = ld_we && !running &&  ld_sel && (int'(ld_col) / R == i);
        end
    end

    for (genvar g = 0; g < P; g++) begin : g_pe
        rrmm_pe #(.N(N), .P(P), .DW(DW), .AW(AW), .IDX(g)) u_pe (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld_a_we  (a_we[g]),
            .ld_b_we  (b_we[g]),
            .ld_row   (ld_row),
            .ld_col   (ld_col),
            .ld_data  (ld_data),
            .running  (running),
            .kk       (kk),
            .lc       (lc),
            .lr       (lr),
            .rnd      (rnd),
            .swap     (swap),
            .xfer_en  (xfer_en),
            .xfer_idx (xfer_idx),
            .nb_in    (ring[(g + P - 1) % P]),
            .nb_out   (ring[g]),
            .rd_row   (rd_row),
            .rd_col   (rd_col),
            .rd_val   (pe_rd[g])
        );
    end

    // Register the C element from the element owning the addressed row.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= pe_rd[int'(rd_row) / R];
    end

endmodule

// File: tb/rrmm_top_test.sv
// Directed bench for rrmm_top: one task per scenario, each checks its results.
module rrmm_top_test;
    localparam int N  = 4;
    localparam int P  = 2;
    localparam int DW = 8;
    localparam int AW = 2 * DW + 2;
    localparam int T_RUN = N * N * N / P;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_we = 1'b0, ld_sel = 1'b0, start = 1'b0;
    logic [1:0]    ld_row = '0, ld_col = '0, rd_row = '0, rd_col = '0;
    logic [DW-1:0] ld_data = '0;
    logic          done;
    logic [AW-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    longint ma [N][N];
    longint mb [N][N];

    always #4 clk = ~clk;

    rrmm_top #(.N(N), .P(P), .DW(DW), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_sel(ld_sel),
        .ld_row(ld_row), .ld_col(ld_col), .ld_data(ld_data), .start(start),
        .done(done), .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
    );

    task automatic chk(input string req, input longint act, input longint exp,
                       input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint cexp(input int r, input int c);
        longint s = 0;
        for (int k = 0; k < N; k++) s += ma[r][k] * mb[k][c];
        return s;
    endfunction

    task automatic load1(input logic sel, input int r, input int c, input longint v);
        ld_we = 1'b1; ld_sel = sel; ld_row = 2'(r); ld_col = 2'(c);
        ld_data = DW'(v);
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic load_all(input bit do_a);
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                if (do_a) load1(1'b0, r, c, ma[r][c]);
                load1(1'b1, r, c, mb[r][c]);
            end
    endtask

    // Pulse start and check the completion edge count (R3).
    task automatic run(input string req, input bit poke);
        int cnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R3", done, 0, "done right after start");
        while (!done && cnt < 1000) begin
            if (poke && cnt == 5) begin
                ld_we = 1'b1; ld_sel = 1'b0; ld_row = 0; ld_col = 0; ld_data = 8'd99;
                start = 1'b1;
            end else begin
                ld_we = 1'b0; start = 1'b0;
            end
            @(negedge clk);
            cnt++;
        end
        ld_we = 1'b0; start = 1'b0;
        chk(req, cnt, T_RUN, "edges from start to done");
    endtask

    task automatic check_c(input string req);
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                rd_row = 2'(r); rd_col = 2'(c);
                @(negedge clk);
                chk(req, rd_data, cexp(r, c), $sformatf("C[%0d][%0d]", r, c));
            end
    endtask

    task automatic t_reset();
        chk("R1", done, 0, "done after reset");
        for (int r = 0; r < N; r++) begin
            rd_row = 2'(r); rd_col = 2'(N - 1 - r);
            @(negedge clk);
            chk("R1", rd_data, 0, "C after reset");
        end
    endtask

    task automatic t_identity();
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                ma[r][c] = (r == c) ? 1 : 0;
                mb[r][c] = r * N + c + 1;
            end
        load_all(1'b1);
        run("R3", 1'b0);
        check_c("R2");
    endtask

    task automatic t_general();
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                ma[r][c] = (r * 37 + c * 11 + 5) % 256;
                mb[r][c] = (r * 13 + c * 71 + 200) % 256;
            end
        load_all(1'b1);
        run("R3", 1'b0);
        check_c("R2");
        repeat (3) @(negedge clk);
        chk("R5", done, 1, "done held while idle");
    endtask

    task automatic t_max();
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                ma[r][c] = 255; mb[r][c] = 255;
            end
        load_all(1'b1);
        run("R3", 1'b0);
        check_c("R2");
    endtask

    // Load and start during a run must be ignored (R5, R6).
    task automatic t_busy_poke();
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                ma[r][c] = (r + 2 * c + 1) % 256;
                mb[r][c] = (3 * r + c + 7) % 256;
            end
        load_all(1'b1);
        run("R5", 1'b1);
        check_c("R6");
    endtask

    // Restart without reload, then reload B only (R8).
    task automatic t_restart();
        run("R3", 1'b0);
        check_c("R8");
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) mb[r][c] = (r * 5 + c * 29 + 3) % 256;
        load_all(1'b0);
        run("R3", 1'b0);
        check_c("R8");
    endtask

    // The read port updates exactly one edge after the address (R7).
    task automatic t_readlat();
        rd_row = 2'd0; rd_col = 2'd1;
        @(negedge clk);
        chk("R7", rd_data, cexp(0, 1), "C[0][1]");
        rd_row = 2'd3; rd_col = 2'd2;
        #1;
        chk("R7", rd_data, cexp(0, 1), "before edge holds old address");
        @(negedge clk);
        chk("R7", rd_data, cexp(3, 2), "C[3][2] one edge later");
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_identity();
        t_general();
        t_max();
        t_busy_poke();
        t_restart();
        t_readlat();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule